// File: doc/BRIEF.md
# Precision-Gated Pipelined Unsigned Multiplier

This block multiplies two unsigned W-bit operands (W = 16 by default) in a pipeline that adds one partial-product row per stage. A slowly changing precision setting `prec` says how many low-order operand bits carry meaning. Operand bits at that index and above are forced to zero on entry. Stages at index `prec` and above are frozen, because the product then has at most 2·`prec` significant bits. Within the active stages, the accumulator bits that cannot yet be non-zero are frozen, and so are the operand bits that only a frozen stage would read. The product is taken from the last needed stage, so a result arrives `prec` cycles after its operands are accepted. Register enables stand in for gated clocks.

Operands come in on a valid/ready stream and products leave on another. A stalled output freezes the whole pipeline. While the output holds a product that is not taken, `in_ready` is low. Software changes `prec` only while no operation is in flight, and the new value may be used from the next cycle. Bits that a frozen register still holds from an earlier setting are masked wherever they are read, so a smaller precision never picks up stale data.

Top module: `prec_gated_mult`

## Requirements
- R1: For every effective precision p from 1 to W, each accepted operand pair yields `out_product` = (in_a mod 2^p) × (in_b mod 2^p).
- R2: Operand bits at index p and above have no effect on the product.
- R3: With `out_ready` held high, `out_valid` rises exactly p cycles after the cycle in which `in_valid` and `in_ready` are both high. When p is 1, the result appears in the very next cycle.
- R4: A `prec` value of 0 acts as p = 1, and any value above W acts as p = W.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and in the next cycle `out_valid` stays high with `out_product` unchanged.
- R6: Whenever `out_valid` is low, `in_ready` is high.
- R7: Products leave in the order their operands were accepted, one product for each accepted pair and no extra ones.
- R8: During reset and right after it, `out_valid` is low and `in_ready` is high.
- R9: Whenever `out_valid` is high, every `out_product` bit at index 2p and above is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prec | input | $clog2(W+1) | Requested operand precision, quasi-static |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Operand pair taken this cycle if valid |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_product | output | 2W | Product |

## Verification
Random full-width operands with stray high bits are run at every precision. This separates correct input masking and correct stage selection from a pipeline that only happens to work at full width. All-ones operands exercise the longest carry chains in the widest active accumulator bits, which shows whether the per-bit freeze boundary sits one bit too low. Single isolated operations measure the latency at each precision, including the out-of-range settings 0 and 31. Random `out_ready` patterns under continuous traffic expose lost, duplicated or reordered products and outputs that are not held while stalled.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  // Map a requested precision onto the supported range 1..w.
  function automatic int clamp_prec(input int raw, input int w);
    if (raw < 1) return 1;
    if (raw > w) return w;
    return raw;
  endfunction

endpackage

// File: rtl/pgm_prec_dec.sv
module pgm_prec_dec #(
  parameter int W  = 16,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [PW-1:0] prec_raw,
  output logic [PW-1:0] prec_eff,
  output logic [W-1:0]  stage_on,
  output logic [W-1:0]  op_mask
);
  import pgm_pkg::*;

  always_comb begin
    prec_eff = PW'(clamp_prec(int'(prec_raw), W));
    for (int s = 0; s < W; s++) begin
      stage_on[s] = (s < int'(prec_eff));
      op_mask[s]  = (s < int'(prec_eff));
    end
  end

endmodule

// File: rtl/pgm_row_stage.sv
module pgm_row_stage #(
  parameter int W  = 16,
  parameter int PW = $clog2(W + 1),
  parameter int S  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            on,
  input  logic [PW-1:0]   pe,
  input  logic [2*W-1:0]  acc_i,
  input  logic [W-1:0]    x_i,
  input  logic [W-1:0]    y_i,
  input  logic            v_i,
  output logic [2*W-1:0]  acc_o,
  output logic [W-1:0]    x_o,
  output logic [W-1:0]    y_o,
  output logic            v_o
);
  localparam int AW = 2 * W;

  logic [AW-1:0] acc_r, acc_d, acc_en;
  logic [W-1:0]  x_r, x_en;
  logic [W-1:0]  y_r, y_en;
  logic          v_r;

  // Row S of the array: the multiplicand shifted by S, if multiplier bit S is set.
  always_comb begin
    acc_d = acc_i + (y_i[S] ? ({{W{1'b0}}, x_i} << S) : '0);
    // Sum of rows 0..S with p-bit operands fits in p+S+1 bits.
    for (int j = 0; j < AW; j++)
      acc_en[j] = on && (j < int'(pe) + S + 1);
    // The multiplicand is carried on only if a later stage is active.
    for (int j = 0; j < W; j++)
      x_en[j] = on && (j < int'(pe)) && (S + 1 < int'(pe));
    // Multiplier bit j is carried only until stage j, and only if j < p.
    for (int j = 0; j < W; j++)
      y_en[j] = on && (j > S) && (j < int'(pe));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
      x_r   <= '0;
      y_r   <= '0;
      v_r   <= 1'b0;
    end else if (adv) begin
      for (int j = 0; j < AW; j++)
        if (acc_en[j]) acc_r[j] <= acc_d[j];
      for (int j = 0; j < W; j++)
        if (x_en[j]) x_r[j] <= x_i[j];
      for (int j = 0; j < W; j++)
        if (y_en[j]) y_r[j] <= y_i[j];
      v_r <= on ? v_i : 1'b0;
    end
  end

  // Frozen bits may hold values from an earlier setting: mask them on read.
  assign acc_o = acc_r & acc_en;
  assign x_o   = x_r & x_en;
  assign y_o   = y_r & y_en;
  assign v_o   = v_r;

endmodule

// File: rtl/pgm_out_sel.sv
module pgm_out_sel #(
  parameter int W  = 16,
  parameter int PW = $clog2(W + 1)
) (
  input  logic [PW-1:0]          pe,
  input  logic [W-1:0][2*W-1:0]  acc_all,
  input  logic [W-1:0]           v_all,
  output logic [2*W-1:0]         product,
  output logic                   valid
);
  logic [PW-1:0] idx;

  always_comb begin
    idx     = pe - PW'(1);
    product = acc_all[idx];
    valid   = v_all[idx];
  end

endmodule

// File: rtl/prec_gated_mult.sv
module prec_gated_mult #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(W+1)-1:0]   prec,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [W-1:0]             in_a,
  input  logic [W-1:0]             in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [2*W-1:0]           out_product
);
  localparam int PW = $clog2(W + 1);
  localparam int AW = 2 * W;

  logic [PW-1:0]        pe;
  logic [W-1:0]         stage_on;
  logic [W-1:0]         op_mask;
  logic                 adv;
  logic [W:0][AW-1:0]   acc_l;
  logic [W:0][W-1:0]    x_l;
  logic [W:0][W-1:0]    y_l;
  logic [W:0]           v_l;
  logic                 unused_tail;

  pgm_prec_dec #(.W(W), .PW(PW)) u_dec (
    .prec_raw (prec),
    .prec_eff (pe),
    .stage_on (stage_on),
    .op_mask  (op_mask)
  );

  // A product that is not taken freezes every stage.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign acc_l[0] = '0;
  assign x_l[0]   = in_a & op_mask;
  assign y_l[0]   = in_b & op_mask;
  assign v_l[0]   = in_valid;

  for (genvar s = 0; s < W; s++) begin : g_stage
    pgm_row_stage #(.W(W), .PW(PW), .S(s)) u_row (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .on    (stage_on[s]),
      .pe    (pe),
      .acc_i (acc_l[s]),
      .x_i   (x_l[s]),
      .y_i   (y_l[s]),
      .v_i   (v_l[s]),
      .acc_o (acc_l[s+1]),
      .x_o   (x_l[s+1]),
      .y_o   (y_l[s+1]),
      .v_o   (v_l[s+1])
    );
  end

  assign unused_tail = ^{x_l[W], y_l[W]};

  pgm_out_sel #(.W(W), .PW(PW)) u_sel (
    .pe      (pe),
    .acc_all (acc_l[W:1]),
    .v_all   (v_l[W:1]),
    .product (out_product),
    .valid   (out_valid)
  );

endmodule

// File: rtl/pgm_chk.sv
module pgm_chk #(
  parameter int W  = 16,
  parameter int PW = $clog2(W + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PW-1:0]   prec,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2*W-1:0]  out_product
);
  import pgm_pkg::*;

  int p_c;
  always_comb p_c = clamp_prec(int'(prec), W);

  // R8
  p_reset_idle_r8: assert property (@(posedge clk) !rst_n |-> !out_valid);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_product));

  p_stall_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_product >> (2 * p_c)) == '0));

  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && p_c == 1 |=> out_valid);

endmodule

bind prec_gated_mult pgm_chk #(.W(W), .PW($clog2(W + 1))) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prec        (prec),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_product (out_product)
);

// File: tb/sim_prec_gated_mult.sv
module sim_prec_gated_mult;
  localparam int W  = 16;
  localparam int PW = $clog2(W + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PW-1:0]   prec = PW'(W);
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [W-1:0]    in_a = '0;
  logic [W-1:0]    in_b = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [2*W-1:0]  out_product;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;
  bit lat_on = 0;
  int lat_exp = 0;
  bit hold_pending = 0;
  logic [2*W-1:0] held;

  logic [2*W-1:0] exp_q[$];
  int             cyc_q[$];
  string          tag_q[$];

  always #2 clk = ~clk;

  prec_gated_mult #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .prec(prec),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_product(out_product)
  );

  function automatic int eff_p(input int raw);
    if (raw < 1) return 1;
    if (raw > W) return W;
    return raw;
  endfunction

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input int p);
    logic [2*W-1:0] m;
    m = (64'd1 << p) - 1;
    return (a & m[W-1:0]) * (b & m[W-1:0]);
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs for this cycle are already set; observe, then go to the next falling edge.
  task automatic cycle();
    #1;
    if (hold_pending) begin
      check("R5 valid held", {31'd0, out_valid}, 1);
      check("R5 product held", out_product, held);
      hold_pending = 0;
    end
    if (!out_valid) check("R6 ready when idle", {31'd0, in_ready}, 1);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 no spurious product", 1, 0);
      end else begin
        logic [2*W-1:0] e;
        int c0;
        string t;
        e = exp_q.pop_front();
        c0 = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_product, e);
        check("R9 upper bits zero", out_product >> (2 * eff_p(int'(prec))), 0);
        if (lat_on) check("R3 latency", cyc - c0, lat_exp);
      end
    end
    if (out_valid && !out_ready) begin
      check("R5 ready low on stall", {31'd0, in_ready}, 0);
      hold_pending = 1;
      held = out_product;
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_mul(in_a, in_b, eff_p(int'(prec))));
      cyc_q.push_back(cyc);
      tag_q.push_back(((in_a | in_b) >> eff_p(int'(prec))) != 0 ? "R2 stray bits" : "R1 product");
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < W + 4; i++) cycle();
    check("R7 all products delivered", exp_q.size(), 0);
  endtask

  task automatic one_op(input logic [W-1:0] a, input logic [W-1:0] b, input int pexp);
    lat_on = 1;
    lat_exp = pexp;
    out_ready = 1'b1;
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    cycle();
    in_valid = 1'b0;
    drain();
    lat_on = 0;
  endtask

  task automatic random_burst(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom % 10) < 7;
      out_ready = ($urandom % 10) < 7;
      in_a = W'($urandom);
      in_b = W'($urandom);
      cycle();
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R8 valid low in reset", {31'd0, out_valid}, 0);
    check("R8 ready high in reset", {31'd0, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R8 valid low after reset", {31'd0, out_valid}, 0);
    check("R8 ready high after reset", {31'd0, in_ready}, 1);
    @(negedge clk);

    for (int p = W; p >= 1; p--) begin
      prec = PW'(p);
      drain();
      one_op(W'($urandom), W'($urandom), p);        // R3
      one_op('1, '1, p);                            // R1 all ones, R2 stray above p
      random_burst(40);
    end
    for (int p = 1; p <= W; p++) begin
      prec = PW'(p);
      drain();
      one_op(W'($urandom), W'($urandom), p);
      random_burst(20);
    end

    // R4: out-of-range settings
    prec = '0;
    drain();
    one_op('1, 16'h0003, 1);
    random_burst(20);
    prec = PW'(31);
    drain();
    one_op('1, '1, W);
    random_burst(20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule